// File: doc/BRIEF.md
# Tile-mode VRAM slot sequencer

This block produces the fixed memory-access schedule of one scanline for a tile-based video display processor. It runs from the pixel clock. Each VRAM slot lasts two pixel clocks, and a line holds 171 slots. For every slot the block reports four things: the kind of access, the sprite, column or sprite-pair index the access refers to, the pattern word number, and whether the slot belongs to the external (CPU) port. It also drives the active-low horizontal sync at its fixed slot positions.

The schedule is not uniform. Sprite rendering comes in groups of six slots. The dedicated sprite-Y scan comes as one run of eight slots. Background fetching comes in groups of sixteen slots, and each of these groups carries one external slot and three sprite-Y slots. The remaining external slots sit in clusters at the start and end of the line. No refresh slots are scheduled.

Alongside the schedule, a combinational remapper spreads a 14-bit logical VRAM address onto the DRAM row and column bits. It uses a non-linear bit order.

Top module: `vram_slot_seq`

## Requirements
- R1: `slot_o` holds each value for exactly two pixel clocks and counts 0,1,…,170, then wraps to 0. `slot_start_o` is high on the first of the two clocks and low on the second.
- R2: Slots 0–11 cover sprites 0–3 and slots 17–28 cover sprites 4–7. Each is split into two six-slot groups for sprites N and N+1. A group runs, in this order: X/name read of N, X/name read of N+1, pattern of N word 0, pattern of N word 1, pattern of N+1 word 0, pattern of N+1 word 1. Type codes: X/name = 1, sprite pattern = 2. `acc_idx_o` carries the sprite number and `acc_word_o` carries the word number.
- R3: Slots 31–38 are sprite-Y reads (type 5) of pairs 0–7. Pair p covers sprites 2p and 2p+1 and is carried in `acc_idx_o`.
- R4: Slots 39–166 form eight background groups. For slot s, let o = s−39, k = o/16, c = (o/4)%4, p = o%4, and column = 4k+c. The value of p selects the access: p=0 is a name-table read (type 3) of that column; p=2 and p=3 are background pattern reads (type 4) of that column, words 0 and 1.
- R5: For p=1 with c≠0 the slot is a sprite-Y read of pair 8+3k+c−1. Across a line, the sprite-Y slots cover pairs 0–31 (sprites 0–63), each exactly once and in ascending order.
- R6: The following slots are external: 12–16, 29–30, 167–170, and the p=1, c=0 slot of each background group. That is 19 per line. In these slots `ext_slot_o`=1, type = 0, index = 0 and word = 0. In every other slot `ext_slot_o`=0.
- R7: `hsync_no` is low for slots 14 through 26 and high in all other slots.
- R8: Each line contains exactly 8 X/name, 16 sprite-pattern, 32 name-table, 64 background-pattern, 32 sprite-Y and 19 external slots.
- R9: `vram_row_o` equals logical address bits 8:1. `vram_col_o` equals {A13,A12,A11,A10,A9,A0}, from bit 5 down to bit 0.
- R10: While `rst_ni` is low, and directly after it rises, the sequencer sits at slot 0 on its first clock. It reports an X/name read of sprite 0, with `hsync_no` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| log_addr_i | input | 14 | Logical VRAM address to remap |
| slot_o | output | 8 | Current slot number in the line |
| slot_start_o | output | 1 | High on the first pixel clock of a slot |
| acc_type_o | output | 3 | Access kind: 0 ext, 1 X/name, 2 sprite pattern, 3 name, 4 bg pattern, 5 sprite Y |
| acc_idx_o | output | 6 | Sprite, column or sprite-pair index |
| acc_word_o | output | 1 | Pattern word number |
| ext_slot_o | output | 1 | Slot is granted to the external port |
| hsync_no | output | 1 | Horizontal sync, active low |
| vram_row_o | output | 8 | DRAM row address |
| vram_col_o | output | 6 | DRAM column address |

## Verification
Two kinds of event share slots in this block: the sync edges and the fetch slots. The falling edge of `hsync_no` lands in the same slot as an external slot, slot 14. Its rising edge lands in the same slot as the first pattern word of sprite 7, slot 27. The line wrap puts the last external slot right next to the first X/name read. The bench walks several complete lines, one pixel clock at a time, and compares every output against a slot map it computes itself. This way the sync and access outputs are judged together in those shared slots. It also asserts reset in the middle of a line, to confirm that the schedule restarts cleanly at slot 0.

// File: rtl/vram_slot_pkg.sv
package vram_slot_pkg;
  localparam int unsigned LINE_SLOTS = 171;
  localparam int unsigned SLOT_W     = $clog2(LINE_SLOTS);
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned LADDR_W    = 14;
  localparam int unsigned ROW_W      = 8;
  localparam int unsigned COL_W      = 6;

  localparam int unsigned SPR_PHASES = 2;
  localparam int unsigned SPR_PH_LEN = 12;
  localparam logic [SLOT_W-1:0] SPR_PH_BASE [SPR_PHASES] = '{8'd0, 8'd17};

  localparam logic [SLOT_W-1:0] YSCAN_BASE = 8'd31;
  localparam logic [SLOT_W-1:0] YSCAN_END  = 8'd39;
  localparam logic [SLOT_W-1:0] BG_BASE    = 8'd39;
  localparam logic [SLOT_W-1:0] BG_END     = 8'd167;
  localparam logic [SLOT_W-1:0] HS_FALL    = 8'd14;
  localparam logic [SLOT_W-1:0] HS_RISE    = 8'd27;

  typedef enum logic [2:0] {
    ACC_EXT     = 3'd0,
    ACC_SPR_XN  = 3'd1,
    ACC_SPR_PAT = 3'd2,
    ACC_NAME    = 3'd3,
    ACC_BG_PAT  = 3'd4,
    ACC_SPR_Y   = 3'd5
  } acc_e;

  typedef struct packed {
    acc_e             kind;
    logic [IDX_W-1:0] idx;
    logic             word;
    logic             ext;
  } slot_info_t;
endpackage

// File: rtl/vram_slot_timer.sv
module vram_slot_timer
  import vram_slot_pkg::*;
#(
  parameter int unsigned CLKS_PER_SLOT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic              start_o
);
  localparam int unsigned PH_W = (CLKS_PER_SLOT > 1) ? $clog2(CLKS_PER_SLOT) : 1;
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(CLKS_PER_SLOT - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(LINE_SLOTS - 1);

  logic [PH_W-1:0]   phase_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
      slot_q  <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign slot_o  = slot_q;
  assign start_o = (phase_q == '0);
endmodule

// File: rtl/vram_slot_decode.sv
module vram_slot_decode
  import vram_slot_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  output slot_info_t        info_o,
  output logic              hsync_n_o
);
  logic [SPR_PHASES-1:0] spr_hit;
  logic [SLOT_W-1:0]     spr_off [SPR_PHASES];

  for (genvar g = 0; g < SPR_PHASES; g++) begin : g_spr_ph
    assign spr_off[g] = slot_i - SPR_PH_BASE[g];
    assign spr_hit[g] = (slot_i >= SPR_PH_BASE[g]) &&
                        (slot_i <  SPR_PH_BASE[g] + SLOT_W'(SPR_PH_LEN));
  end

  logic [SLOT_W-1:0] bg_off;
  logic [2:0]        bg_grp;
  logic [1:0]        bg_col;
  logic [1:0]        bg_pos;
  assign bg_off = slot_i - BG_BASE;
  assign bg_grp = bg_off[6:4];
  assign bg_col = bg_off[3:2];
  assign bg_pos = bg_off[1:0];

  always_comb begin
    logic [3:0]       off;
    logic             hi;
    logic [3:0]       r;
    logic [IDX_W-1:0] sbase;
    info_o = '{kind: ACC_EXT, idx: '0, word: 1'b0, ext: 1'b1};
    off    = '0;
    hi     = 1'b0;
    r      = '0;
    sbase  = '0;
    for (int g = 0; g < SPR_PHASES; g++) begin
      if (spr_hit[g]) begin
        off   = spr_off[g][3:0];
        hi    = (off >= 4'd6);
        r     = hi ? off - 4'd6 : off;
        sbase = IDX_W'(4 * g) + (hi ? IDX_W'(2) : IDX_W'(0));
        info_o.ext = 1'b0;
        if (r < 4'd2) begin
          info_o.kind = ACC_SPR_XN;
          info_o.idx  = sbase + IDX_W'(r[0]);
        end else begin
          info_o.kind = ACC_SPR_PAT;
          info_o.idx  = sbase + ((r >= 4'd4) ? IDX_W'(1) : IDX_W'(0));
          info_o.word = r[0];
        end
      end
    end
    if (slot_i >= YSCAN_BASE && slot_i < YSCAN_END) begin
      info_o.kind = ACC_SPR_Y;
      info_o.idx  = IDX_W'(slot_i - YSCAN_BASE);
      info_o.ext  = 1'b0;
    end
    if (slot_i >= BG_BASE && slot_i < BG_END) begin
      unique case (bg_pos)
        2'd0: begin
          info_o.kind = ACC_NAME;
          info_o.idx  = {1'b0, bg_grp, bg_col};
          info_o.ext  = 1'b0;
        end
        2'd1: begin
          if (bg_col != 2'd0) begin
            info_o.kind = ACC_SPR_Y;
            info_o.idx  = IDX_W'(7) + IDX_W'(bg_grp) * IDX_W'(3) + IDX_W'(bg_col);
            info_o.ext  = 1'b0;
          end
        end
        default: begin
          info_o.kind = ACC_BG_PAT;
          info_o.idx  = {1'b0, bg_grp, bg_col};
          info_o.word = bg_pos[0];
          info_o.ext  = 1'b0;
        end
      endcase
    end
  end

  assign hsync_n_o = !(slot_i >= HS_FALL && slot_i < HS_RISE);
endmodule

// File: rtl/vram_addr_map.sv
module vram_addr_map
  import vram_slot_pkg::*;
(
  input  logic [LADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]   row_o,
  output logic [COL_W-1:0]   col_o
);
  assign row_o = addr_i[8:1];
  assign col_o = {addr_i[13:10], addr_i[9], addr_i[0]};
endmodule

// File: rtl/vram_slot_seq.sv
module vram_slot_seq
  import vram_slot_pkg::*;
#(
  parameter int unsigned CLKS_PER_SLOT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LADDR_W-1:0] log_addr_i,
  output logic [SLOT_W-1:0]  slot_o,
  output logic               slot_start_o,
  output logic [2:0]         acc_type_o,
  output logic [IDX_W-1:0]   acc_idx_o,
  output logic               acc_word_o,
  output logic               ext_slot_o,
  output logic               hsync_no,
  output logic [ROW_W-1:0]   vram_row_o,
  output logic [COL_W-1:0]   vram_col_o
);
  logic [SLOT_W-1:0] slot;
  slot_info_t        info;

  vram_slot_timer #(.CLKS_PER_SLOT(CLKS_PER_SLOT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_o  (slot),
    .start_o (slot_start_o)
  );

  vram_slot_decode u_decode (
    .slot_i    (slot),
    .info_o    (info),
    .hsync_n_o (hsync_no)
  );

  vram_addr_map u_amap (
    .addr_i (log_addr_i),
    .row_o  (vram_row_o),
    .col_o  (vram_col_o)
  );

  assign slot_o     = slot;
  assign acc_type_o = info.kind;
  assign acc_idx_o  = info.idx;
  assign acc_word_o = info.word;
  assign ext_slot_o = info.ext;
endmodule

// File: rtl/vram_slot_seq_chk.sv
module vram_slot_seq_chk
  import vram_slot_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W-1:0] slot_o,
  input logic              slot_start_o,
  input logic [2:0]        acc_type_o,
  input logic [IDX_W-1:0]  acc_idx_o,
  input logic              acc_word_o,
  input logic              ext_slot_o,
  input logic              hsync_no
);
  // R1: second clock of a slot keeps the number
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |=> (!slot_start_o && $stable(slot_o)));
  // R1: next slot number after the second clock
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start_o |=> (slot_start_o &&
      slot_o == (($past(slot_o) == 8'd170) ? 8'd0 : $past(slot_o) + 8'd1)));
  // R6: external slot carries no index or word
  a_r6_ext_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_slot_o |-> (acc_type_o == 3'd0 && acc_idx_o == '0 && !acc_word_o));
  // R7: sync edges at fixed slots
  a_r7_hs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_no) |-> (slot_o == 8'd14 && slot_start_o));
  a_r7_hs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_no) |-> (slot_o == 8'd27 && slot_start_o));
  // R2: word number only on pattern reads
  a_r2_word_pat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_word_o |-> (acc_type_o == 3'd2 || acc_type_o == 3'd4));
  // R2: sprite index range
  a_r2_spr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_o == 3'd1 || acc_type_o == 3'd2) |-> acc_idx_o < 6'd8);
endmodule

bind vram_slot_seq vram_slot_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_o       (slot_o),
  .slot_start_o (slot_start_o),
  .acc_type_o   (acc_type_o),
  .acc_idx_o    (acc_idx_o),
  .acc_word_o   (acc_word_o),
  .ext_slot_o   (ext_slot_o),
  .hsync_no     (hsync_no)
);

// File: tb/vram_slot_seq_tb.sv
module vram_slot_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] log_addr_i = '0;
  logic [7:0]  slot_o;
  logic        slot_start_o;
  logic [2:0]  acc_type_o;
  logic [5:0]  acc_idx_o;
  logic        acc_word_o;
  logic        ext_slot_o;
  logic        hsync_no;
  logic [7:0]  vram_row_o;
  logic [5:0]  vram_col_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  vram_slot_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .log_addr_i(log_addr_i),
    .slot_o(slot_o), .slot_start_o(slot_start_o), .acc_type_o(acc_type_o),
    .acc_idx_o(acc_idx_o), .acc_word_o(acc_word_o), .ext_slot_o(ext_slot_o),
    .hsync_no(hsync_no), .vram_row_o(vram_row_o), .vram_col_o(vram_col_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected slot map, written from the requirement text
  task automatic exp_map(input int s, output int t, output int ix, output int w, output int hs);
    t = 0; ix = 0; w = 0;
    hs = (s >= 14 && s <= 26) ? 0 : 1;
    if (s <= 11 || (s >= 17 && s <= 28)) begin
      int b, o, pair;
      b    = (s <= 11) ? 0 : 17;
      o    = (s - b) % 6;
      pair = ((s <= 11) ? 0 : 4) + 2 * ((s - b) / 6);
      case (o)
        0: begin t = 1; ix = pair; end
        1: begin t = 1; ix = pair + 1; end
        2, 3: begin t = 2; ix = pair; w = o - 2; end
        default: begin t = 2; ix = pair + 1; w = o - 4; end
      endcase
    end else if (s >= 31 && s <= 38) begin
      t = 5; ix = s - 31;
    end else if (s >= 39 && s <= 166) begin
      int o, k, c, p;
      o = s - 39; k = o / 16; c = (o / 4) % 4; p = o % 4;
      if (p == 0) begin t = 3; ix = 4 * k + c; end
      else if (p == 1) begin
        if (c != 0) begin t = 5; ix = 8 + 3 * k + c - 1; end
      end else begin t = 4; ix = 4 * k + c; w = p - 2; end
    end
  endtask

  task automatic run_lines(input int nlines);
    int cnt[6];
    int last_y;
    for (int n = 0; n < nlines * 342; n++) begin
      int s, t, ix, w, hs;
      s = (n / 2) % 171;
      exp_map(s, t, ix, w, hs);
      if (s == 0 && n % 2 == 0) begin
        foreach (cnt[i]) cnt[i] = 0;
        last_y = -1;
      end
      chk(slot_o == 8'(s), "R1 slot", slot_o, s);
      chk(slot_start_o == (n % 2 == 0), "R1 start", slot_start_o, n % 2 == 0);
      chk(acc_type_o == 3'(t), (t == 0) ? "R6 type" : (t <= 2) ? "R2 type" :
          (t == 5) ? "R5 type" : "R4 type", acc_type_o, t);
      chk(acc_idx_o == 6'(ix), (t == 5 && s < 39) ? "R3 idx" : "R4 idx", acc_idx_o, ix);
      chk(acc_word_o == w, "R2 word", acc_word_o, w);
      chk(ext_slot_o == (t == 0), "R6 ext", ext_slot_o, t == 0);
      chk(hsync_no == hs, "R7 hsync", hsync_no, hs);
      if (n % 2 == 0) begin
        if (acc_type_o <= 3'd5) cnt[acc_type_o]++;
        if (acc_type_o == 3'd5) begin
          chk(int'(acc_idx_o) == last_y + 1, "R5 y order", acc_idx_o, last_y + 1);
          last_y = acc_idx_o;
        end
      end
      if (s == 170 && n % 2 == 1) begin
        chk(cnt[1] == 8,  "R8 xn count",  cnt[1], 8);
        chk(cnt[2] == 16, "R8 spat count", cnt[2], 16);
        chk(cnt[3] == 32, "R8 name count", cnt[3], 32);
        chk(cnt[4] == 64, "R8 bpat count", cnt[4], 64);
        chk(cnt[5] == 32, "R8 y count",    cnt[5], 32);
        chk(cnt[0] == 19, "R6 ext count",  cnt[0], 19);
        chk(last_y == 31, "R5 y last",     last_y, 31);
      end
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic chk_reset_state();
    chk(slot_o == 8'd0, "R10 slot", slot_o, 0);
    chk(slot_start_o == 1'b1, "R10 start", slot_start_o, 1);
    chk(acc_type_o == 3'd1 && acc_idx_o == 6'd0, "R10 access", acc_type_o, 1);
    chk(hsync_no == 1'b1, "R10 hsync", hsync_no, 1);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_reset_state();
    rst_ni = 1'b1;
    run_lines(3);
    // mid-line reset
    repeat (101) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk_reset_state();
    run_lines(1);
    // R9 address remap, exhaustive
    for (int a = 0; a < 16384; a++) begin
      int er, ec;
      log_addr_i = 14'(a);
      #1;
      er = (a >> 1) & 255;
      ec = ((a >> 10) << 2) | (((a >> 9) & 1) << 1) | (a & 1);
      chk(vram_row_o == 8'(er), "R9 row", vram_row_o, er);
      chk(vram_col_o == 6'(ec), "R9 col", vram_col_o, ec);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule